// File: doc/BRIEF.md
# Dual-Mode Block Transfer Engine

This single-channel engine copies a programmed number of bytes from a peripheral data port into memory over a system bus that it shares with the processor. The processor keeps running its own program the whole time. It is held off only on the cycles when the arbiter has handed the bus to the engine, so it never has to save or restore any state. Software loads a start address, a byte count and a mode bit, then pulses `start`. The engine asks for the bus with `busReq` and waits for `busGrant`. On each cycle where it holds the bus and the peripheral has a byte ready, it takes that byte, acknowledges the peripheral and writes the byte to memory.

The mode bit sets how long the engine keeps the bus. In burst mode it holds its request from the first byte to the last, so the whole block takes one bus tenure. In cycle-stealing mode it drops its request after every byte, which hands the bus back to the processor for at least one clock. A block of N bytes then takes N tenures. When the last byte has been written, a sticky `done` flag rises. It stays set until it is cleared or a new block is started.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: A synchronous reset leaves the engine idle, with `busReq`, `done`, `memWe` and `perAck` all low.
- R2: `memWe` is high in a cycle only if both `busReq` and `busGrant` were high in the cycle before.
- R3: Byte k of a block (k counting from 0) is written at address base+k, taken modulo 2^ADDR_W. `memData` carries the `perData` value that was present in the capture cycle. `perAck` pulses high for exactly the cycles in which `memWe` is high.
- R4: When `cfgData[0]` was written as 0 through `wrMode` (burst mode), a block of N bytes produces exactly N memory writes within one bus tenure, meaning a single rising edge of `busReq`. This holds for N = 1000.
- R5: When `cfgData[0]` was written as 1 (cycle-stealing mode), a block of N bytes produces N tenures. After every byte except the last, `busReq` is low for exactly one cycle and then rises again. This holds for N = 1000.
- R6: `done` rises in the same cycle as the write of the last byte. At that point `busReq` is already low. `done` then stays high until `clearDone` or a new `start`.
- R7: While a block is in progress, pulses on `wrAddr`, `wrCount`, `wrMode` and `start` have no effect. The block keeps its original addresses, length and mode.
- R8: Starting with a count of 0 raises `done` on the next cycle and never raises `busReq`.
- R9: No byte is captured in a cycle where `perReq` is low, even while the bus is granted.
- R10: `wrAddr` loads `cfgData[ADDR_W-1:0]` as the base address, and `wrCount` loads `cfgData[COUNT_W-1:0]` as the byte count. Both take effect only while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgData | input | CFG_W | Write data for the configuration registers |
| wrAddr | input | 1 | Load base address from cfgData |
| wrCount | input | 1 | Load byte count from cfgData |
| wrMode | input | 1 | Load mode from cfgData[0] (0 burst, 1 cycle stealing) |
| start | input | 1 | Begin a block transfer |
| clearDone | input | 1 | Clear the done flag |
| busReq | output | 1 | Bus request to the arbiter |
| busGrant | input | 1 | Bus grant from the arbiter |
| memAddr | output | ADDR_W | Memory write address |
| memData | output | DATA_W | Memory write data |
| memWe | output | 1 | Memory write strobe |
| perReq | input | 1 | Peripheral has a byte ready |
| perData | input | DATA_W | Peripheral byte |
| perAck | output | 1 | Byte taken, one-cycle pulse |
| done | output | 1 | Sticky completion flag |

## Verification
A corrupted address or count register shows up on the very first write that follows: either `memAddr` leaves the base+k sequence, or the number of writes before `done` differs from the programmed length. A control state that leaves the request path wrong shows within a few cycles. A request that stays high in cycle-stealing mode, or that falls in the middle of a burst, changes the tenure count. A write with no grant in the previous cycle is visible on the very next edge.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic loadAddr;
    logic loadCount;
    logic loadMode;
    logic moveByte;
  } dpStrobe_t;

endpackage

// File: rtl/dma_xfer_datapath.sv
module dma_xfer_datapath
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int COUNT_W = 16,
  parameter int DATA_W  = 8,
  parameter int CFG_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [DATA_W-1:0] perData,
  output logic              countZero,
  output logic              countOne,
  output logic              stealMode,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memWe,
  output logic              perAck
);

  localparam logic [COUNT_W-1:0] COUNT_ONE = COUNT_W'(1);
  localparam logic [ADDR_W-1:0]  ADDR_STEP = ADDR_W'(1);

  logic [ADDR_W-1:0]  addrReg;
  logic [COUNT_W-1:0] countReg;

  assign countZero = (countReg == '0);
  assign countOne  = (countReg == COUNT_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg   <= '0;
      countReg  <= '0;
      stealMode <= 1'b0;
      memAddr   <= '0;
      memData   <= '0;
      memWe     <= 1'b0;
      perAck    <= 1'b0;
    end else begin
      memWe  <= strobe.moveByte;
      perAck <= strobe.moveByte;
      if (strobe.loadAddr)  addrReg   <= cfgData[ADDR_W-1:0];
      if (strobe.loadCount) countReg  <= cfgData[COUNT_W-1:0];
      if (strobe.loadMode)  stealMode <= cfgData[0];
      if (strobe.moveByte) begin
        memAddr  <= addrReg;
        memData  <= perData;
        addrReg  <= addrReg + ADDR_STEP;
        countReg <= countReg - COUNT_ONE;
      end
    end
  end

endmodule

// File: rtl/dma_xfer_control.sv
module dma_xfer_control
  import dma_xfer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      clearDone,
  input  logic      wrAddr,
  input  logic      wrCount,
  input  logic      wrMode,
  input  logic      busGrant,
  input  logic      perReq,
  input  logic      countZero,
  input  logic      countOne,
  input  logic      stealMode,
  output dpStrobe_t strobe,
  output logic      busReq,
  output logic      done
);

  ctrlState_t state, stateNext;
  logic busReqNext, doneNext;

  always_comb begin
    stateNext  = state;
    busReqNext = busReq;
    doneNext   = done;
    strobe     = '0;
    unique case (state)
      ST_IDLE: begin
        // configuration only accepted while idle
        strobe.loadAddr  = wrAddr;
        strobe.loadCount = wrCount;
        strobe.loadMode  = wrMode;
        if (clearDone) doneNext = 1'b0;
        if (start) begin
          if (countZero) begin
            doneNext = 1'b1;
          end else begin
            doneNext   = 1'b0;
            busReqNext = 1'b1;
            stateNext  = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (busGrant && perReq) begin
          strobe.moveByte = 1'b1;
          if (countOne) begin
            busReqNext = 1'b0;
            doneNext   = 1'b1;
            stateNext  = ST_IDLE;
          end else if (stealMode) begin
            busReqNext = 1'b0;
            stateNext  = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        busReqNext = 1'b1;
        stateNext  = ST_REQ;
      end
      default: begin
        busReqNext = 1'b0;
        stateNext  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      busReq <= 1'b0;
      done   <= 1'b0;
    end else begin
      state  <= stateNext;
      busReq <= busReqNext;
      done   <= doneNext;
    end
  end

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int COUNT_W = 16,
  parameter int DATA_W  = 8,
  parameter int CFG_W   = (ADDR_W > COUNT_W) ? ADDR_W : COUNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              wrAddr,
  input  logic              wrCount,
  input  logic              wrMode,
  input  logic              start,
  input  logic              clearDone,
  output logic              busReq,
  input  logic              busGrant,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memWe,
  input  logic              perReq,
  input  logic [DATA_W-1:0] perData,
  output logic              perAck,
  output logic              done
);

  dpStrobe_t strobe;
  logic countZero, countOne, stealMode;

  dma_xfer_control u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .clearDone (clearDone),
    .wrAddr    (wrAddr),
    .wrCount   (wrCount),
    .wrMode    (wrMode),
    .busGrant  (busGrant),
    .perReq    (perReq),
    .countZero (countZero),
    .countOne  (countOne),
    .stealMode (stealMode),
    .strobe    (strobe),
    .busReq    (busReq),
    .done      (done)
  );

  dma_xfer_datapath #(
    .ADDR_W  (ADDR_W),
    .COUNT_W (COUNT_W),
    .DATA_W  (DATA_W),
    .CFG_W   (CFG_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .cfgData   (cfgData),
    .perData   (perData),
    .countZero (countZero),
    .countOne  (countOne),
    .stealMode (stealMode),
    .memAddr   (memAddr),
    .memData   (memData),
    .memWe     (memWe),
    .perAck    (perAck)
  );

endmodule

// File: rtl/dma_xfer_ctrl_chk.sv
module dma_xfer_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              clearDone,
  input logic              busReq,
  input logic              busGrant,
  input logic              perReq,
  input logic              memWe,
  input logic              perAck,
  input logic              done,
  input logic [ADDR_W-1:0] memAddr
);

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busReq && !done && !memWe && !perAck));

  a_r2_write_after_grant: assert property (@(posedge clk) disable iff (rst)
    memWe |-> ($past(busReq) && $past(busGrant)));

  a_r3_ack_with_write: assert property (@(posedge clk) disable iff (rst)
    memWe |-> perAck);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (memWe && $past(memWe)) |-> (memAddr == $past(memAddr) + ADDR_W'(1)));

  a_r5_gap_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ($fell(busReq) && !done) |=> busReq);

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !clearDone && !start) |=> done);

  a_r9_byte_needs_request: assert property (@(posedge clk) disable iff (rst)
    memWe |-> $past(perReq));

endmodule

bind dma_xfer_ctrl dma_xfer_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .clearDone (clearDone),
  .busReq    (busReq),
  .busGrant  (busGrant),
  .perReq    (perReq),
  .memWe     (memWe),
  .perAck    (perAck),
  .done      (done),
  .memAddr   (memAddr)
);

// File: tb/dma_xfer_ctrl_bench.sv
module dma_xfer_ctrl_bench;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] cfgData = '0;
  logic wrAddr = 0, wrCount = 0, wrMode = 0, start = 0, clearDone = 0;
  logic busReq, busGrant, memWe, perAck, done;
  logic perReq = 0;
  logic [DATA_W-1:0] perData = '0;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData;

  always #5 clk = ~clk;

  dma_xfer_ctrl u_dma_xfer_ctrl (
    .clk(clk), .rst(rst), .cfgData(cfgData), .wrAddr(wrAddr), .wrCount(wrCount),
    .wrMode(wrMode), .start(start), .clearDone(clearDone), .busReq(busReq),
    .busGrant(busGrant), .memAddr(memAddr), .memData(memData), .memWe(memWe),
    .perReq(perReq), .perData(perData), .perAck(perAck), .done(done)
  );

  int nChecks = 0, nFail = 0;
  bit finished = 0, monOn = 0, perForceLow = 0, cpuBusy = 0;
  int bytesSeen = 0, tenures = 0;
  logic [ADDR_W-1:0] expAddr = '0;
  bit curSteal = 0, gapPending = 0;
  logic prevBusReq = 0, prevGrant = 0, prevPerReq = 0;
  logic [DATA_W-1:0] prevData = '0;

  // arbiter model: grant follows request one cycle later unless the processor holds the bus
  always @(posedge clk) busGrant <= rst ? 1'b0 : (busReq && !cpuBusy);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] nextAddr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // monitor and random peripheral/processor driver
  always @(negedge clk) begin
    if (monOn) begin
      if (gapPending) begin
        check(busReq == 1'b1, "R5 request back after gap", busReq, 1);
        gapPending = 0;
      end
      if (memWe) begin
        check(prevBusReq && prevGrant, "R2 write without grant", {prevBusReq, prevGrant}, 3);
        check(prevPerReq, "R9 byte without peripheral request", prevPerReq, 1);
        check(memAddr == expAddr, "R3 address", memAddr, expAddr);
        check(memData == prevData, "R3 data", memData, prevData);
        check(perAck, "R3 ack with write", perAck, 1);
        expAddr = nextAddr(expAddr);
        bytesSeen++;
        if (curSteal) begin
          check(busReq == 1'b0, "R5 request dropped after byte", busReq, 0);
          if (!done) gapPending = 1;
        end
      end else begin
        check(!perAck, "R3 ack without write", perAck, 0);
      end
      if (busReq && !prevBusReq) tenures++;
    end
    perReq  = perForceLow ? 1'b0 : (($urandom % 4) != 0);
    perData = DATA_W'($urandom);
    cpuBusy = (($urandom % 8) == 0);
    prevBusReq = busReq;
    prevGrant  = busGrant;
    prevPerReq = perReq;
    prevData   = perData;
  end

  task automatic pulse(input int which, input logic [15:0] val);
    @(negedge clk);
    cfgData = val;
    case (which)
      0: wrAddr = 1;
      1: wrCount = 1;
      2: wrMode = 1;
      3: start = 1;
      default: clearDone = 1;
    endcase
    @(negedge clk);
    wrAddr = 0; wrCount = 0; wrMode = 0; start = 0; clearDone = 0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic runBlock(input logic [15:0] base, input int cnt, input bit steal, input bit meddle);
    pulse(0, base);
    pulse(1, 16'(cnt));
    pulse(2, {15'd0, steal});
    expAddr = base; bytesSeen = 0; tenures = 0; curSteal = steal; gapPending = 0;
    pulse(3, 16'd0);
    if (meddle) begin
      repeat (4) @(negedge clk);
      pulse(0, 16'hDEAD);
      pulse(1, 16'd3);
      pulse(2, {15'd0, ~steal});
      pulse(3, 16'd0);
    end
    waitDone();
    @(negedge clk);
    check(done == 1'b1, "R6 done after block", done, 1);
    check(busReq == 1'b0, "R6 bus released", busReq, 0);
    check(bytesSeen == cnt, meddle ? "R7 length unchanged" : (steal ? "R5 byte count" : "R4 byte count"), bytesSeen, cnt);
    check(tenures == (steal ? cnt : 1), steal ? "R5 tenures" : "R4 single tenure", tenures, steal ? cnt : 1);
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R6 done held", done, 1);
    pulse(4, 16'd0);
    check(done == 1'b0, "R6 done cleared", done, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busReq && !done && !memWe && !perAck, "R1 reset state", {busReq, done, memWe, perAck}, 0);
    rst = 0;
    @(negedge clk);
    check(!busReq && !done && !memWe && !perAck, "R1 idle after reset", {busReq, done, memWe, perAck}, 0);
    monOn = 1;

    // R8 zero-length start
    pulse(1, 16'd0);
    tenures = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(done == 1'b1, "R8 done on zero count", done, 1);
    check(busReq == 1'b0, "R8 no request", busReq, 0);
    repeat (4) @(negedge clk);
    check(tenures == 0, "R8 no tenure", tenures, 0);
    pulse(4, 16'd0);

    // R10 register loads, R4 burst, R5 steal, address wrap for R3
    runBlock(16'h1000, 8, 0, 0);
    runBlock(16'h2000, 8, 1, 0);
    runBlock(16'hFFFE, 4, 0, 0);
    runBlock(16'h3000, 1, 1, 0);

    // R7 writes during an active block are ignored
    runBlock(16'h4000, 30, 1, 1);
    runBlock(16'h5000, 30, 0, 1);

    // R9 peripheral not ready while granted
    perForceLow = 1;
    pulse(0, 16'h6000); pulse(1, 16'd5); pulse(2, 16'd0);
    expAddr = 16'h6000; bytesSeen = 0; tenures = 0; curSteal = 0;
    pulse(3, 16'd0);
    repeat (30) @(negedge clk);
    check(bytesSeen == 0, "R9 no capture without request", bytesSeen, 0);
    check(busReq == 1'b1, "R9 request held while waiting", busReq, 1);
    perForceLow = 0;
    waitDone();
    @(negedge clk);
    check(bytesSeen == 5, "R9 completes after request", bytesSeen, 5);
    pulse(4, 16'd0);

    // random blocks
    for (int k = 0; k < 12; k++) begin
      runBlock(16'($urandom), 1 + ($urandom % 40), bit'($urandom % 2), 0);
    end

    // 1000-byte blocks in both modes
    runBlock(16'h8000, 1000, 0, 0);
    runBlock(16'h9000, 1000, 1, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule